// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a packed vector by an amount taken from the same lane of a second packed vector, so each lane can move by a different distance. It is used as the execution datapath for variable-count vector shifts. The caller picks the direction with `op_sel`, the lane size with `lane_sel` and the active vector length with `len_sel`.

A lane's count is read as a full unsigned number and is never reduced modulo the lane width. A count at or above the width empties the lane for logical shifts. For an arithmetic shift it fills the lane with its sign bit. Shifts never carry bits from one lane into the next. The result is registered, so `out_valid` follows `in_valid` by exactly one clock.

Top module: `vshift_unit`

## Requirements
- R1: `lane_sel`=0 splits the vector into 32-bit lanes and `lane_sel`=1 splits it into 64-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: The amount for lane k is the whole unsigned value of lane k of `count_in`, including every upper bit (for example 0x3001 in a 32-bit lane).
- R3: `op_sel`=00 is a logical left shift. Zeros enter at bit 0 of the lane.
- R4: `op_sel`=01 and `op_sel`=11 are logical right shifts. Zeros enter at the top bit of the lane.
- R5: `op_sel`=10 with 32-bit lanes is an arithmetic right shift that fills with copies of lane bit 31. With 64-bit lanes, `op_sel`=10 acts as a logical right shift.
- R6: A count greater than or equal to the lane width gives zero for logical shifts. For an arithmetic shift it gives all copies of the sign bit.
- R7: A count of zero passes the lane through unchanged. A count of W-1 is an ordinary in-range shift.
- R8: Each lane is shifted in isolation. No bit crosses a lane boundary, even when neighbouring lanes use different counts.
- R9: With `len_sel`=0 (128-bit vector), result bits 255..128 are zero. With `len_sel`=1, all 256 bits are computed.
- R10: `result` loads the shifted vector on a clock where `in_valid`=1. It holds its value on a clock where `in_valid`=0. `out_valid` equals `in_valid` delayed by one clock.
- R11: When `rst_n` is low at a rising clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_sel | input | 2 | 00 left logical, 01/11 right logical, 10 right arithmetic |
| lane_sel | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| len_sel | input | 1 | 0: 128-bit vector, 1: 256-bit vector |
| data_in | input | 256 | Packed data operand |
| count_in | input | 256 | Packed per-lane shift counts |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 256 | Registered shifted vector |

## Verification
On every cycle, the assertions check the registered timing and hold behaviour, the clearing of the upper half for 128-bit vectors, pass-through for all-zero counts, zero entry into bit 0 of each 64-bit lane on left shifts, and the reset state. The per-lane arithmetic can only be shown by the bench scenarios. These cover counts that straddle the lane width, counts with only upper bits set, sign fill on negative and positive lanes, the arithmetic-to-logical fallback for 64-bit lanes, and neighbouring lanes with unrelated counts. The bench compares these against a reference computed lane by lane from the requirements.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_ARITH = 2'b10,
        SH_RALT  = 2'b11
    } shift_op_e;

    localparam int NARROW_W = 32;
    localparam int WIDE_W   = 64;

endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] din,
    input  logic [LANE_W-1:0] cnt,
    input  logic              go_left,
    input  logic              go_arith,
    output logic [LANE_W-1:0] dout
);
    localparam int SH_W = $clog2(LANE_W);

    logic              over;
    logic [SH_W-1:0]   amt;
    logic              fill;
    logic [LANE_W-1:0] fill_mask;

    // Any set bit at or above SH_W means count >= LANE_W (R6, R2)
    assign over      = |cnt[LANE_W-1:SH_W];
    assign amt       = cnt[SH_W-1:0];
    assign fill      = go_arith & din[LANE_W-1];
    assign fill_mask = ~({LANE_W{1'b1}} >> amt);

    always_comb begin
        if (over) begin
            dout = go_left ? '0 : {LANE_W{fill}};
        end else if (go_left) begin
            dout = din << amt;
        end else begin
            dout = (din >> amt) | (fill ? fill_mask : '0);
        end
    end
endmodule

// File: rtl/vshift_bank.sv
module vshift_bank #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 32
) (
    input  logic [VEC_W-1:0] data,
    input  logic [VEC_W-1:0] counts,
    input  logic             go_left,
    input  logic             go_arith,
    output logic [VEC_W-1:0] shifted
);
    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        vshift_lane #(.LANE_W(LANE_W)) u_lane (
            .din      (data   [k*LANE_W +: LANE_W]),
            .cnt      (counts [k*LANE_W +: LANE_W]),
            .go_left  (go_left),
            .go_arith (go_arith),
            .dout     (shifted[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic             lane_sel,
    input  logic             len_sel,
    input  logic [VEC_W-1:0] data_in,
    input  logic [VEC_W-1:0] count_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
    } stage_t;

    shift_op_e        op;
    logic             go_left;
    logic             go_arith;
    logic [VEC_W-1:0] narrow_res;
    logic [VEC_W-1:0] wide_res;
    stage_t           st_d, st_q;

    assign op       = shift_op_e'(op_sel);
    assign go_left  = (op == SH_LEFT);
    assign go_arith = (op == SH_ARITH);

    vshift_bank #(.VEC_W(VEC_W), .LANE_W(NARROW_W)) u_narrow (
        .data     (data_in),
        .counts   (count_in),
        .go_left  (go_left),
        .go_arith (go_arith),
        .shifted  (narrow_res)
    );

    // Arithmetic requests fall back to logical right on wide lanes (R5)
    vshift_bank #(.VEC_W(VEC_W), .LANE_W(WIDE_W)) u_wide (
        .data     (data_in),
        .counts   (count_in),
        .go_left  (go_left),
        .go_arith (1'b0),
        .shifted  (wide_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.vec = lane_sel ? wide_res : narrow_res;
            if (!len_sel) begin
                st_d.vec[VEC_W-1:HALF_W] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.vec;
endmodule

// File: rtl/vshift_chk.sv
module vshift_chk
    import vshift_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic             lane_sel,
    input logic             len_sel,
    input logic [VEC_W-1:0] data_in,
    input logic [VEC_W-1:0] count_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    localparam int HALF_W = VEC_W / 2;
    localparam int N_WIDE = VEC_W / WIDE_W;

    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !len_sel) |=> (result[VEC_W-1:HALF_W] == '0));

    a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel && count_in == '0) |=> (result == $past(data_in)));

    for (genvar k = 0; k < N_WIDE; k++) begin : g_wl
        a_r3_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_sel && op_sel == SH_LEFT && count_in[k*WIDE_W +: WIDE_W] != '0)
            |=> (result[k*WIDE_W] == 1'b0));
    end
endmodule

bind vshift_unit vshift_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_vshift_unit.sv
module sim_vshift_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         lane_sel = 1'b0;
    logic         len_sel = 1'b1;
    logic [255:0] data_in = '0;
    logic [255:0] count_in = '0;
    logic         out_valid;
    logic [255:0] result;

    int total = 0;
    int bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    vshift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sel(lane_sel), .len_sel(len_sel), .data_in(data_in),
        .count_in(count_in), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] rnd64(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic next_rand(output logic [255:0] v);
        for (int i = 0; i < 4; i++) begin
            seed = rnd64(seed);
            v[i*64 +: 64] = seed;
        end
    endtask

    // Reference computed per lane from the requirements
    function automatic logic [255:0] model(input logic [255:0] d, input logic [255:0] c,
                                           input logic [1:0] op, input logic wide, input logic full);
        logic [255:0] r;
        logic [31:0]  x32, n32, y32;
        logic [63:0]  x64, n64, y64;
        r = '0;
        if (!wide) begin
            for (int k = 0; k < 8; k++) begin
                x32 = d[k*32 +: 32];
                n32 = c[k*32 +: 32];
                if (op == 2'b00)      y32 = (n32 >= 32) ? 32'h0 : (x32 << n32[4:0]);
                else if (op == 2'b10) y32 = (n32 >= 32) ? {32{x32[31]}} : 32'($signed(x32) >>> n32[4:0]);
                else                  y32 = (n32 >= 32) ? 32'h0 : (x32 >> n32[4:0]);
                r[k*32 +: 32] = y32;
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                x64 = d[k*64 +: 64];
                n64 = c[k*64 +: 64];
                if (op == 2'b00) y64 = (n64 >= 64) ? 64'h0 : (x64 << n64[5:0]);
                else             y64 = (n64 >= 64) ? 64'h0 : (x64 >> n64[5:0]);
                r[k*64 +: 64] = y64;
            end
        end
        if (!full) r[255:128] = '0;
        return r;
    endfunction

    task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Starts and ends at a falling edge; result is sampled one clock later
    task automatic run_vec(input string tag, input logic [255:0] d, input logic [255:0] c,
                           input logic [1:0] op, input logic wide, input logic full);
        in_valid = 1'b1;
        data_in  = d;
        count_in = c;
        op_sel   = op;
        lane_sel = wide;
        len_sel  = full;
        @(negedge clk);
        check(tag, result, model(d, c, op, wide, full));
        check("R10 valid", {255'b0, out_valid}, 256'd1);
    endtask

    function automatic logic [255:0] fill32(input logic [31:0] v);
        return {8{v}};
    endfunction

    logic [255:0] dv, cv, held;
    string tg;

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset result", result, '0);
        check("R11 reset valid", {255'b0, out_valid}, '0);
        rst_n = 1'b1;

        dv = 256'h1eddddac09633294_f95c8eec40725633_8800e95bbf9962c3_43d3cda0238499fd;
        run_vec("R7 zero count 32", dv, '0, 2'b10, 1'b0, 1'b1);
        run_vec("R7 zero count 64", dv, '0, 2'b01, 1'b1, 1'b1);
        run_vec("R7 count 31 arith", dv, fill32(32'd31), 2'b10, 1'b0, 1'b1);
        run_vec("R7 count 63 right", dv, {4{64'd63}}, 2'b01, 1'b1, 1'b1);
        run_vec("R2 R6 count 0x3001 left", dv, fill32(32'h3001), 2'b00, 1'b0, 1'b1);
        run_vec("R2 R6 count 0x3001 arith", dv, fill32(32'h3001), 2'b10, 1'b0, 1'b1);
        run_vec("R2 R6 upper-bit count 64", dv, {4{64'hfedcba9876543210}}, 2'b00, 1'b1, 1'b1);
        run_vec("R6 count 32 arith", dv, fill32(32'd32), 2'b10, 1'b0, 1'b1);
        run_vec("R5 arith on wide lanes", dv, {4{64'd6}}, 2'b10, 1'b1, 1'b1);
        run_vec("R4 alt right encoding", dv, fill32(32'd5), 2'b11, 1'b0, 1'b1);
        cv = 256'h0000000300000000_000000160000001F_0000000600000001_0000300100000006;
        run_vec("R8 mixed counts 32", dv, cv, 2'b00, 1'b0, 1'b1);
        run_vec("R8 mixed counts arith", dv, cv, 2'b10, 1'b0, 1'b1);
        run_vec("R1 same counts wide lanes", dv, cv, 2'b01, 1'b1, 1'b1);
        run_vec("R9 short vector", dv, fill32(32'd1), 2'b00, 1'b0, 1'b0);

        // R10: idle cycle keeps the previous result
        held = result;
        in_valid = 1'b0;
        data_in  = ~dv;
        count_in = '0;
        @(negedge clk);
        check("R10 hold result", result, held);
        check("R10 idle valid", {255'b0, out_valid}, '0);

        // Sweep counts across and beyond both lane widths, all modes
        for (int b = 0; b < 70; b++) begin
            for (int op = 0; op < 4; op++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int f = 0; f < 2; f++) begin
                        next_rand(dv);
                        cv = '0;
                        if (w == 0) begin
                            for (int k = 0; k < 8; k++) cv[k*32 +: 32] = 32'((b + 7*k) % 70);
                        end else begin
                            for (int k = 0; k < 4; k++) cv[k*64 +: 64] = 64'((b + 13*k) % 70);
                        end
                        if (op == 0)      tg = "R3 sweep";
                        else if (op == 2) tg = "R5 sweep";
                        else              tg = "R4 sweep";
                        run_vec(tg, dv, cv, 2'(op), 1'(w), 1'(f));
                    end
                end
            end
        end

        // R11: reset clears a loaded result
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 reset after use", result, '0);
        check("R11 valid after use", {255'b0, out_valid}, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule